// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a system watchdog. The oscillator clock first passes a fixed divider, then a prescaler with eight power-of-two ratios, and then drives a wide up-counter. If the counter wraps while the watchdog is armed, the block raises a one-cycle reset request. The system reset generator turns that request into a chip reset. Software must clear the watchdog often enough to keep the request from firing.

One 8-bit control register holds all the settings. It is written and read through a plain register port that has a write strobe, write data and a read data bus that always shows the register. The register has an arm bit, a clear bit that drops back to zero by itself, a bit that keeps the watchdog counting while the processor is idle, and a 3-bit divide select. An idle input from the power manager stops the count unless the idle-run bit is set. A parameter can shrink the fixed divider and the counter width so that simulation runs faster. The register encoding does not change with this parameter.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset the register reads 0x00, the watchdog is disarmed with select code 0 and idle-run off, all internal counts are zero, and `rst_req_o` is low.
- R2: Register bit positions: arm = bit 7, clear = bit 6, idle-run = bit 5, divide select = bits 2..0. Bits 4 and 3 always read 0, whatever value is written to them.
- R3: A write with bit 6 set makes bit 6 read 1 for exactly one cycle. It then reads 0 unless a new write sets it again.
- R4: The cycle in which the clear bit is 1 resets the fixed divider, the prescaler and the counter. The next request therefore comes one full timeout period after that cycle. No request is raised in the clear cycle itself.
- R5: Select code k (0..7) sets a prescale ratio of 2^(k+1). The timeout is FIX_DIV × 2^(k+1) × 2^CNT_W counting cycles. With the defaults this is 12 × ratio × 16384 oscillator periods.
- R6: While the arm bit is 0 nothing counts, no request is raised, and the count that has built up is held.
- R7: While `idle_i` is 1 and idle-run is 0, the count freezes and no request is raised. Counting resumes from the held value when `idle_i` falls.
- R8: While `idle_i` is 1 and idle-run is 1, counting goes on at the normal rate.
- R9: `rst_req_o` is a pulse one cycle long that follows the final counting cycle. The counter wraps to zero, so the next pulse follows one full period later if nothing clears the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Current register contents |
| idle_i | input | 1 | Processor idle indication |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The internal counts cannot be seen directly. A wrong value in the divider, the prescaler or the counter shows up only as a request that comes too early, too late, twice, or not at all. It is therefore seen no earlier than the end of the timeout period in which it happens. The bench keeps a behavioural count of elapsed cycles and compares both outputs on every clock, so a single-cycle shift in the request is caught at once. A clear bit that sticks or is lost shows up at the read port in the next cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W    = 3;
  localparam int REG_W    = 8;
  localparam int ARM_BIT  = 7;
  localparam int CLR_BIT  = 6;
  localparam int IRUN_BIT = 5;
  localparam int SEL_LSB  = 0;

  typedef struct packed {
    logic             arm;
    logic             clr;
    logic             idle_run;
    logic [SEL_W-1:0] sel;
  } wdt_ctl_t;

  function automatic logic [REG_W-1:0] ctl_to_bus(input wdt_ctl_t c);
    logic [REG_W-1:0] b;
    b = '0;
    b[ARM_BIT]  = c.arm;
    b[CLR_BIT]  = c.clr;
    b[IRUN_BIT] = c.idle_run;
    b[SEL_LSB +: SEL_W] = c.sel;
    return b;
  endfunction

  function automatic wdt_ctl_t bus_to_ctl(input logic [REG_W-1:0] b);
    wdt_ctl_t c;
    c.arm      = b[ARM_BIT];
    c.clr      = b[CLR_BIT];
    c.idle_run = b[IRUN_BIT];
    c.sel      = b[SEL_LSB +: SEL_W];
    return c;
  endfunction
endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output wdt_ctl_t         ctl_o,
  output logic [REG_W-1:0] rdata_o
);
  wdt_ctl_t ctl_q;
  wdt_ctl_t ctl_wr;
  logic     unused_rsvd_bits;

  assign ctl_wr           = bus_to_ctl(wdata_i);
  assign unused_rsvd_bits = ^wdata_i[4:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_i) begin
      ctl_q <= ctl_wr;
    end else begin
      // clear bit lives for one cycle only
      ctl_q.clr <= 1'b0;
    end
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = ctl_to_bus(ctl_q);
endmodule

// File: rtl/wdt_prediv.sv
module wdt_prediv #(
  parameter int FIX_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (FIX_DIV <= 1) begin : g_bypass
      assign tick_o = run_i & ~clr_i;
    end else begin : g_div
      localparam int DW = $clog2(FIX_DIV);
      localparam logic [DW-1:0] LAST = DW'(FIX_DIV - 1);
      logic [DW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q <= '0;
        end else if (clr_i) begin
          phase_q <= '0;
        end else if (run_i) begin
          phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
      end

      assign tick_o = run_i & ~clr_i & (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PW = 1 << SEL_W;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] mask;

  // mask selects the low (sel+1) bits: ratio 2^(sel+1)
  genvar gi;
  generate
    for (gi = 0; gi < PW; gi++) begin : g_mask
      assign mask[gi] = (SEL_W'(gi) <= sel_i) || (gi == 0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (clr_i) begin
      pcnt_q <= '0;
    end else if (tick_i) begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign tick_o = tick_i & ~clr_i & ((pcnt_q & mask) == mask);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      ovf_q <= &cnt_q;
    end else begin
      ovf_q <= 1'b0;
    end
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
  import wdt_pkg::*;
#(
  parameter int FIX_DIV = 12,
  parameter int CNT_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfr_wr_i,
  input  logic [REG_W-1:0] sfr_wdata_i,
  output logic [REG_W-1:0] sfr_rdata_o,
  input  logic             idle_i,
  output logic             rst_req_o
);
  wdt_ctl_t ctl;
  logic     run;
  logic     fix_tick;
  logic     pre_tick;

  wdt_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (sfr_wr_i),
    .wdata_i (sfr_wdata_i),
    .ctl_o   (ctl),
    .rdata_o (sfr_rdata_o)
  );

  assign run = ctl.arm & (~idle_i | ctl.idle_run);

  wdt_prediv #(.FIX_DIV(FIX_DIV)) u_prediv (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ctl.clr),
    .run_i  (run),
    .tick_o (fix_tick)
  );

  wdt_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ctl.clr),
    .tick_i (fix_tick),
    .sel_i  (ctl.sel),
    .tick_o (pre_tick)
  );

  wdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ctl.clr),
    .tick_i (pre_tick),
    .ovf_o  (rst_req_o)
  );
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       sfr_wr_i,
  input logic [7:0] sfr_rdata_o,
  input logic       idle_i,
  input logic       rst_req_o
);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_clr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rdata_o[6] && !sfr_wr_i) |=> !sfr_rdata_o[6]);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rdata_o[4:3] == 2'b00);

  p_disarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_rdata_o[7] |=> !rst_req_o);

  p_clr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rdata_o[6] |=> !rst_req_o);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && !sfr_rdata_o[5]) |=> !rst_req_o);
endmodule

bind wdt_prescaled wdt_checks u_wdt_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .sfr_wr_i    (sfr_wr_i),
  .sfr_rdata_o (sfr_rdata_o),
  .idle_i      (idle_i),
  .rst_req_o   (rst_req_o)
);

// File: tb/test_wdt_prescaled.sv
`timescale 1ns/1ps
module test_wdt_prescaled;
  localparam int FDIV = 3;
  localparam int CW   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       idle = 1'b0;
  logic       req;

  int    n_chk = 0;
  int    n_bad = 0;
  int    pulses = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // behavioural model state
  bit m_arm, m_clr, m_irun;
  int m_sel;
  int elapsed;
  bit m_req;

  always #10 clk = ~clk;

  wdt_prescaled #(.FIX_DIV(FDIV), .CNT_W(CW)) i_wdt_prescaled (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfr_wr_i    (wr),
    .sfr_wdata_i (wdata),
    .sfr_rdata_o (rdata),
    .idle_i      (idle),
    .rst_req_o   (req)
  );

  function automatic int period(input int s);
    return FDIV * (2 << s) * (1 << CW);
  endfunction

  function automatic int model_bus();
    return (int'(m_arm) << 7) | (int'(m_clr) << 6) | (int'(m_irun) << 5) | m_sel;
  endfunction

  task automatic chk(input string t, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", t, act, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_arm = 0; m_clr = 0; m_irun = 0; m_sel = 0; elapsed = 0; m_req = 0;
    end else begin
      m_req = 0;
      if (m_clr) elapsed = 0;
      else if (m_arm && (!idle || m_irun)) begin
        elapsed++;
        if (elapsed == period(m_sel)) begin
          elapsed = 0;
          m_req = 1;
        end
      end
      if (wr) begin
        m_arm = wdata[7]; m_clr = wdata[6]; m_irun = wdata[5]; m_sel = int'(wdata[2:0]);
      end else begin
        m_clr = 0;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk({tag, " rdata"}, int'(rdata), model_bus());
      chk({tag, " req"}, int'(req), int'(m_req));
      if (req) pulses++;
    end
  end

  task automatic sfr_write(input logic [7:0] v);
    @(negedge clk);
    wr = 1'b1; wdata = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    wait (cycles > 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    finish_run();
  end

  initial begin
    wait_cyc(3);
    chk("R1 reset rdata", int'(rdata), 0);
    chk("R1 reset req", int'(req), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 idle after reset", int'(rdata), 0);

    // R5 / R9: code 0, armed with clear
    tag = "R5";
    sfr_write(8'hC0);
    chk("R3 clear reads one", int'(rdata[6]), 1);
    @(negedge clk);
    chk("R3 clear self drops", int'(rdata[6]), 0);
    pulses = 0;
    wait_cyc(period(0) * 2 + 5);
    chk("R9 two pulses over two periods", pulses, 2);

    // R4: clear partway resets progress
    tag = "R4";
    sfr_write(8'hC3);
    wait_cyc(period(3) / 2);
    pulses = 0;
    sfr_write(8'hC3);
    wait_cyc(period(3) - 10);
    chk("R4 no early pulse after clear", pulses, 0);
    wait_cyc(20);
    chk("R4 pulse one period after clear", pulses, 1);

    // R7: idle freezes with idle-run off
    tag = "R7";
    sfr_write(8'hC0);
    wait_cyc(50);
    idle = 1'b1;
    pulses = 0;
    wait_cyc(period(0) * 4);
    chk("R7 no pulse while frozen", pulses, 0);
    idle = 1'b0;
    wait_cyc(period(0));
    chk("R7 resumes after idle", pulses, 1);

    // R8: idle counts with idle-run on
    tag = "R8";
    sfr_write(8'hE0);
    idle = 1'b1;
    pulses = 0;
    wait_cyc(period(0) * 2 + 5);
    chk("R8 counts in idle", pulses, 2);
    idle = 1'b0;

    // R6: disarmed
    tag = "R6";
    sfr_write(8'h40);
    pulses = 0;
    wait_cyc(period(0) * 10);
    chk("R6 no pulse disarmed", pulses, 0);
    chk("R6 disarmed rdata", int'(rdata), 8'h00);

    // R2 / R5: reserved bits ignored, largest ratio
    tag = "R2";
    sfr_write(8'hDF);
    chk("R2 readback with clear", int'(rdata), 8'hC7);
    @(negedge clk);
    chk("R2 readback reserved zero", int'(rdata), 8'h87);
    tag = "R5";
    pulses = 0;
    wait_cyc(period(7) - 10);
    chk("R5 no pulse before long timeout", pulses, 0);
    wait_cyc(20);
    chk("R5 pulse at long timeout", pulses, 1);

    finish_run();
  end
endmodule